// File: doc/BRIEF.md
# Recorded Miss-List Prefetcher

This block serves one hardware thread. Software brackets a code region, usually a nest of loops, with directives. On the first pass the block writes the line number of every L1 demand miss into a list, in the order the misses arrive. On each later pass it reads that list ahead of the thread's own demand stream. For every list entry it offers a prefetch request on a valid/ready port, and it keeps only a bounded number of these offers ahead of the position where demand last matched the list.

While a pass is replayed, the block also writes a refined list for the next pass. Each demand miss is compared against a small window of upcoming list entries. A hit moves the matched position past the entry it hit, and any entries it skipped over are dropped. A miss that hits nothing in the window is written into the new list at the current point, and the matched position stays where it was. The list storage has two banks. The bank being written becomes the bank being read when the pass ends, so no copy is needed. A core with four threads uses four instances of this block. All addresses on the ports are 128-byte cache line numbers.

Top module: `list_pf_top`

## Requirements
- R1: After reset `pfValid` and `overflow` are 0 and the list is empty, so a replay started straight after reset offers no prefetch.
- R2: `cmdOp` encodes 2'b01 begin-record, 2'b10 begin-replay, 2'b11 end and 2'b00 no operation, and it is sampled when `cmdValid` is 1. While recording, each accepted miss line is appended to the new list in arrival order, and no prefetch is offered.
- R3: An end command given while recording or replaying makes the newly written list the active one. The next replay offers its entries from index 0 in order, and it offers nothing beyond the last entry.
- R4: During replay, the entry at index i is offered only while i < matched position + PF_AHEAD (default 4). Offers leave one per cycle while `pfReady` is 1.
- R5: A replay miss that equals the active-list entry at offset k (0 <= k < WIN, default 8) from the matched position, with the lowest such k taking priority, moves the matched position forward by k+1. The skipped entries are neither offered afterwards in that pass nor kept in the refined list.
- R6: A replay miss that matches no entry in the window, including an entry at offset WIN or more, is appended to the refined list at the current point, and the matched position is left unchanged.
- R7: When the new list already holds DEPTH (default 64) entries, a further miss is not stored and `overflow` is set. `overflow` stays set until the next begin-record or begin-replay command.
- R8: While `pfValid` is 1 and `pfReady` is 0, and no miss or command arrives, the offer is held: `pfValid` stays 1 and `pfLine` stays stable.
- R9: A miss arriving while the block is idle, or in the same cycle as a command, is ignored and does not enter any list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Directive strobe |
| cmdOp | input | 2 | Directive code (see R2) |
| missValid | input | 1 | Demand miss strobe |
| missLine | input | LINE_W | Line number of the demand miss |
| pfValid | output | 1 | Prefetch offer valid |
| pfReady | input | 1 | Prefetch offer accepted |
| pfLine | output | LINE_W | Line number to prefetch |
| overflow | output | 1 | A miss was lost because the list was full |

## Verification
A directive or a miss is captured at one clock edge. Its effect on `pfValid`, `pfLine` and `overflow` is visible in the cycle that follows, because the outputs are decoded from registers with no further stage. The bench changes inputs a quarter period after a rising edge and samples at the next falling edge. After each miss it waits six cycles, so the window of up to four offers has fully drained before the next event. With that spacing, the order of accepted offers does not depend on timing. A behavioural model of the list, the matched position and the issue position pushes the expected lines into a queue. A monitor compares each accepted offer against the front of that queue.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_REC  = 2'd1,
    MODE_PLAY = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_REC  = 2'b01,
    OP_PLAY = 2'b10,
    OP_END  = 2'b11
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // write missLine into the new-list bank
    logic swap;   // new-list bank becomes the active bank
  } strobe_t;
endpackage

// File: rtl/lpf_data.sv
module lpf_data
  import lpf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LINE_W = 25,
  parameter int WIN    = 8,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OFF_W = $clog2(WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  issIdx,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [PTR_W-1:0]  rdLen,
  input  logic [LINE_W-1:0] missLine,
  output logic              hit,
  output logic [OFF_W-1:0]  hitOff,
  output logic [LINE_W-1:0] pfLine
);
  logic [LINE_W-1:0] bank [2][DEPTH];
  logic              readBank;
  logic [WIN-1:0]    winEq;

  always_ff @(posedge clk) begin
    if (!rstN)          readBank <= 1'b0;
    else if (strb.swap) readBank <= ~readBank;
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) bank[~readBank][wrIdx] <= missLine;
  end

  // lookahead comparators over the active bank
  for (genvar i = 0; i < WIN; i++) begin : g_win
    logic [PTR_W:0] idx;
    logic           inRange;
    assign idx     = {1'b0, rdPtr} + (PTR_W+1)'(i);
    assign inRange = idx < {1'b0, rdLen};
    assign winEq[i] = inRange && (bank[readBank][idx[IDX_W-1:0]] == missLine);
  end

  always_comb begin
    hitOff = '0;
    for (int i = WIN - 1; i >= 0; i--) begin
      if (winEq[i]) hitOff = OFF_W'(i);
    end
  end

  assign hit    = |winEq;
  assign pfLine = bank[readBank][issIdx];
endmodule

// File: rtl/lpf_ctrl.sv
module lpf_ctrl
  import lpf_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int WIN      = 8,
  parameter int PF_AHEAD = 4,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OFF_W = $clog2(WIN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic             missValid,
  input  logic             hit,
  input  logic [OFF_W-1:0] hitOff,
  input  logic             pfReady,
  output strobe_t          strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] issIdx,
  output logic [PTR_W-1:0] rdPtr,
  output logic [PTR_W-1:0] rdLen,
  output logic             pfValid,
  output logic             overflow
);
  mode_e            mode;
  logic [PTR_W-1:0] wrPtr, issPtr;
  logic [PTR_W-1:0] rdAdv, issInc, issNext;
  logic             cmdTake, missTake, room, pfFire, advance;

  assign cmdTake  = cmdValid && (op_e'(cmdOp) != OP_NONE);
  assign missTake = missValid && !cmdTake && (mode != MODE_IDLE);
  assign room     = wrPtr < PTR_W'(DEPTH);
  assign pfValid  = (mode == MODE_PLAY) && (issPtr < rdLen) &&
                    ((issPtr - rdPtr) < PTR_W'(PF_AHEAD));
  assign pfFire   = pfValid && pfReady;
  assign advance  = missTake && (mode == MODE_PLAY) && hit;

  assign rdAdv   = advance ? rdPtr + PTR_W'(hitOff) + PTR_W'(1) : rdPtr;
  assign issInc  = pfFire ? issPtr + PTR_W'(1) : issPtr;
  assign issNext = (issInc < rdAdv) ? rdAdv : issInc;

  assign strb.wrEn = missTake && room;
  assign strb.swap = cmdValid && (op_e'(cmdOp) == OP_END) && (mode != MODE_IDLE);
  assign wrIdx     = wrPtr[IDX_W-1:0];
  assign issIdx    = issPtr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MODE_IDLE;
      wrPtr    <= '0;
      rdPtr    <= '0;
      issPtr   <= '0;
      rdLen    <= '0;
      overflow <= 1'b0;
    end else if (cmdTake) begin
      rdPtr  <= '0;
      issPtr <= '0;
      unique case (op_e'(cmdOp))
        OP_REC: begin
          mode     <= MODE_REC;
          wrPtr    <= '0;
          overflow <= 1'b0;
        end
        OP_PLAY: begin
          mode     <= MODE_PLAY;
          wrPtr    <= '0;
          overflow <= 1'b0;
        end
        default: begin
          if (mode != MODE_IDLE) rdLen <= wrPtr;
          mode <= MODE_IDLE;
        end
      endcase
    end else begin
      if (missTake) begin
        if (room) wrPtr <= wrPtr + PTR_W'(1);
        else      overflow <= 1'b1;
      end
      rdPtr  <= rdAdv;
      issPtr <= issNext;
    end
  end

  // R4
  ahead_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issPtr >= rdPtr) && ((issPtr - rdPtr) <= PTR_W'(PF_AHEAD)));

  // R5
  rd_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PLAY) && !cmdValid |=> rdPtr >= $past(rdPtr));

  // R7
  wr_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= PTR_W'(DEPTH));

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !cmdValid |=> overflow);

  // R8
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && !pfReady && !missValid && !cmdValid |=> pfValid && $stable(issPtr));
endmodule

// File: rtl/list_pf_top.sv
module list_pf_top
  import lpf_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int LINE_W   = 25,
  parameter int WIN      = 8,
  parameter int PF_AHEAD = 4,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OFF_W = $clog2(WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic              missValid,
  input  logic [LINE_W-1:0] missLine,
  output logic              pfValid,
  input  logic              pfReady,
  output logic [LINE_W-1:0] pfLine,
  output logic              overflow
);
  strobe_t          strb;
  logic [IDX_W-1:0] wrIdx, issIdx;
  logic [PTR_W-1:0] rdPtr, rdLen;
  logic             hit;
  logic [OFF_W-1:0] hitOff;

  lpf_ctrl #(.DEPTH(DEPTH), .WIN(WIN), .PF_AHEAD(PF_AHEAD)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .missValid(missValid), .hit(hit), .hitOff(hitOff), .pfReady(pfReady),
    .strb(strb), .wrIdx(wrIdx), .issIdx(issIdx), .rdPtr(rdPtr),
    .rdLen(rdLen), .pfValid(pfValid), .overflow(overflow)
  );

  lpf_data #(.DEPTH(DEPTH), .LINE_W(LINE_W), .WIN(WIN)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .issIdx(issIdx),
    .rdPtr(rdPtr), .rdLen(rdLen), .missLine(missLine),
    .hit(hit), .hitOff(hitOff), .pfLine(pfLine)
  );
endmodule

// File: tb/list_pf_top_tb_top.sv
module list_pf_top_tb_top;
  localparam int CLK_P    = 10;
  localparam int DEPTH    = 64;
  localparam int LINE_W   = 25;
  localparam int WIN      = 8;
  localparam int PF_AHEAD = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, missValid = 1'b0, pfReady = 1'b1;
  logic [1:0] cmdOp = 2'b00;
  logic [LINE_W-1:0] missLine = '0;
  logic pfValid, overflow;
  logic [LINE_W-1:0] pfLine;

  list_pf_top #(.DEPTH(DEPTH), .LINE_W(LINE_W), .WIN(WIN), .PF_AHEAD(PF_AHEAD)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .missValid(missValid), .missLine(missLine), .pfValid(pfValid),
    .pfReady(pfReady), .pfLine(pfLine), .overflow(overflow)
  );

  always #(CLK_P/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  string phaseTag = "R1";
  logic [LINE_W-1:0] expQ[$];
  logic [LINE_W-1:0] refList[$], newList[$];
  int rp = 0, iss = 0;
  bit active = 0, playing = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each accepted offer
  always @(negedge clk) begin
    if (rstN && pfValid && pfReady) begin
      if (expQ.size() == 0) check(1'b0, phaseTag, "unexpected prefetch", pfLine, 0);
      else begin
        logic [LINE_W-1:0] e;
        e = expQ.pop_front();
        check(pfLine == e, phaseTag, "prefetch line", pfLine, e);
      end
    end
  end

  // reference model
  task automatic pushIssue();
    if (iss < rp) iss = rp;
    while (iss < refList.size() && iss < rp + PF_AHEAD) begin
      expQ.push_back(refList[iss]);
      iss++;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic doCmd(logic [1:0] op);
    cmdValid = 1'b1; cmdOp = op;
    tick();
    cmdValid = 1'b0; cmdOp = 2'b00;
    if (op == 2'b01) begin newList.delete(); active = 1; playing = 0; end
    else if (op == 2'b10) begin
      newList.delete(); active = 1; playing = 1; rp = 0; iss = 0; pushIssue();
    end else if (op == 2'b11) begin
      if (active) refList = newList;
      active = 0; playing = 0;
    end
  endtask

  task automatic doMiss(logic [LINE_W-1:0] line);
    missValid = 1'b1; missLine = line;
    if (active) begin
      if (newList.size() < DEPTH) newList.push_back(line);
      if (playing) begin
        for (int k = 0; k < WIN; k++) begin
          if (rp + k < refList.size() && refList[rp + k] == line) begin
            rp = rp + k + 1;
            break;
          end
        end
        pushIssue();
      end
    end
    tick();
    missValid = 1'b0;
  endtask

  task automatic settle();
    repeat (6) tick();
  endtask

  task automatic drained(string tag);
    @(negedge clk);
    check(expQ.size() == 0, tag, "pending expected offers", expQ.size(), 0);
  endtask

  function automatic logic [LINE_W-1:0] lineA(int i);
    return LINE_W'(32'h1000 + i * 3);
  endfunction

  initial begin
    #(CLK_P * 100000);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [LINE_W-1:0] held;
    repeat (3) tick();
    rstN = 1'b1;
    @(negedge clk);
    check(pfValid == 1'b0, "R1", "pfValid after reset", pfValid, 0);
    check(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);
    // R1: replay of empty list offers nothing
    doCmd(2'b10); settle(); @(negedge clk);
    check(pfValid == 1'b0, "R1", "pfValid replaying empty list", pfValid, 0);
    doCmd(2'b11);

    // R2: record ten misses, no offers meanwhile
    phaseTag = "R2";
    doCmd(2'b01);
    for (int i = 0; i < 10; i++) begin
      doMiss(lineA(i)); @(negedge clk);
      check(pfValid == 1'b0, "R2", "pfValid while recording", pfValid, 0);
    end
    doCmd(2'b11);
    // R9: misses while idle are ignored
    doMiss(LINE_W'(32'h7777)); doMiss(LINE_W'(32'h7778));

    // R8: held offer under backpressure, then R3 ordered replay
    phaseTag = "R3";
    pfReady = 1'b0;
    doCmd(2'b10); @(negedge clk);
    check(pfValid == 1'b1, "R8", "pfValid held", pfValid, 1);
    held = pfLine;
    check(pfLine == lineA(0), "R3", "first offer is entry 0", pfLine, lineA(0));
    repeat (3) tick(); @(negedge clk);
    check(pfValid == 1'b1 && pfLine == held, "R8", "offer stable", pfLine, held);
    pfReady = 1'b1;
    settle(); drained("R4");
    // R5 skip A2, R6 insert new line
    phaseTag = "R5";
    doMiss(lineA(0)); settle();
    doMiss(lineA(1)); settle();
    doMiss(lineA(3)); settle();
    phaseTag = "R6";
    doMiss(LINE_W'(32'h5A5A)); settle();
    phaseTag = "R9";
    for (int i = 4; i < 10; i++) begin doMiss(lineA(i)); settle(); end
    drained("R9");
    doCmd(2'b11);

    // second pass over refined list [A0 A1 A3 X A4..A9]
    phaseTag = "R5";
    doCmd(2'b10); settle(); drained("R5");
    doMiss(lineA(0)); settle();
    phaseTag = "R6";
    doMiss(lineA(9)); settle();   // offset 8: outside window
    phaseTag = "R5";
    doMiss(lineA(8)); settle();   // offset 7: jump
    drained("R5");
    // R9: end with a miss in the same cycle; the miss is dropped
    cmdValid = 1'b1; cmdOp = 2'b11; missValid = 1'b1; missLine = LINE_W'(32'h3C3C);
    tick();
    cmdValid = 1'b0; cmdOp = 2'b00; missValid = 1'b0;
    refList = newList; active = 0; playing = 0;

    // third pass: list must be [A0 A9 A8], nothing past its end
    phaseTag = "R3";
    doCmd(2'b10); settle(); drained("R3");
    @(negedge clk);
    check(pfValid == 1'b0, "R3", "no offer past list end", pfValid, 0);
    doCmd(2'b11);

    // R7: overflow
    phaseTag = "R7";
    doCmd(2'b01);
    for (int i = 0; i < DEPTH; i++) doMiss(LINE_W'(32'h20000 + i));
    @(negedge clk);
    check(overflow == 1'b0, "R7", "overflow at exactly DEPTH", overflow, 0);
    doMiss(LINE_W'(32'h2FFFF)); @(negedge clk);
    check(overflow == 1'b1, "R7", "overflow after DEPTH+1", overflow, 1);
    doCmd(2'b11); @(negedge clk);
    check(overflow == 1'b1, "R7", "overflow sticky after end", overflow, 1);
    doCmd(2'b10); @(negedge clk);
    check(overflow == 1'b0, "R7", "overflow cleared by begin", overflow, 0);
    settle(); drained("R7");
    doCmd(2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule